// File: doc/BRIEF.md
# Edge-Select Wakeup Interrupt Controller

This block watches an eight-pin input port and records a chosen transition on each pin in a sticky pending register. For every pin, software sets two things. One enable bit lets that pin's pending bit drive the shared interrupt/wakeup request. One polarity bit picks whether a rising or a falling transition is recorded. The request line serves both as an interrupt to a running core and as the wake signal for a core that is asleep.

Each pin is first resynchronised through two flops. An edge is found by comparing the resynchronised level with its value one cycle earlier. Edges are latched into the pending register whether or not the pin is enabled. Software reaches the pending register only through an atomic exchange. In one access the old contents come back and a new value is written in their place. If an edge lands in the same cycle as an exchange, its bit is merged into the written value. This means that clearing serviced bits can never drop a request that arrives at that moment.

A two-state request machine drives the output. In state `REQ_QUIET` the request is low. It moves to `REQ_RAISED` on the transition "hit" when any pending bit is set on an enabled pin. It falls back to `REQ_QUIET` on the transition "drain" when no enabled pin has a pending bit left. The output follows the pending and enable registers with one cycle of delay.

Top module: `wk_edge_ctrl`

## Requirements
- R1: After reset the enable and polarity registers are 0, every pending bit is 0 and `irq_o` is 0. Reading pending through an exchange returns 0x00.
- R2: When a pin's polarity bit is 0, a low-to-high transition on that pin sets its pending bit and a high-to-low transition does not.
- R3: When a pin's polarity bit is 1, a high-to-low transition sets its pending bit and a low-to-high transition does not. Changing a polarity bit while the pin holds still sets no pending bit.
- R4: A pending bit is recorded whatever the pin's enable bit is. `irq_o` is 1 exactly when some pin has both its pending bit and its enable bit set, one clock after that condition arises.
- R5: An exchange with `xchg_en`=1 returns the pending contents from before the access on `xchg_rdata`. At the clock edge it loads `xchg_wdata` into pending.
- R6: When an exchange writes back the old value with only the serviced bits cleared, every other pending bit stays 1.
- R7: An edge detected in the same clock cycle as an exchange sets its pending bit on top of the written value, so the edge is not lost.
- R8: A pending bit stays 1 after its pin returns to its former level, until an exchange writes 0 to it.
- R9: After an exchange clears every enabled pending bit, `irq_o` returns to 0 one clock later.
- R10: A register write with `cfg_we`=1 loads `cfg_wdata` into the enable register when `cfg_sel`=0 and into the polarity register when `cfg_sel`=1. Bit n of each register belongs to pin n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_i | input | 8 | Asynchronous port pins |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects enable, 1 selects polarity |
| cfg_wdata | input | 8 | Register write data |
| xchg_en | input | 1 | Pending exchange strobe |
| xchg_wdata | input | 8 | Value loaded into pending |
| xchg_rdata | output | 8 | Pending contents before the exchange |
| irq_o | output | 1 | Interrupt/wakeup request |

## Verification
The hardest case is an edge whose detection falls in exactly the cycle of a clearing exchange. This is the one race the merge logic exists for. The bench drives the pin away from the clock edge, then counts two synchroniser stages forward. It places the exchange strobe so that it covers the clock edge at which the detector's pulse is live. A second exchange then shows that the new bit survived the clear. The other checks come from a vector table that changes polarity, enable and pin patterns, and from directed tests of partial clearing and of stickiness.

// File: rtl/wk_pkg.sv
package wk_pkg;
    localparam int PINS = 8;

    typedef enum logic {
        CFG_ENABLE = 1'b0,
        CFG_EDGE   = 1'b1
    } cfg_sel_e;

    typedef enum logic {
        REQ_QUIET  = 1'b0,
        REQ_RAISED = 1'b1
    } req_state_e;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= '0;
                end else if (s == 0) begin
                    chain_q[s] <= async_i;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/wk_edge_det.sv
module wk_edge_det #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] fall_sel_i,
    output logic [WIDTH-1:0] hit_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    genvar p;
    generate
        for (p = 0; p < WIDTH; p++) begin : g_pin
            logic rise, fall;
            always_comb begin
                rise     = level_i[p] & ~prev_q[p];
                fall     = ~level_i[p] & prev_q[p];
                hit_o[p] = fall_sel_i[p] ? fall : rise;
            end
        end
    endgenerate

    // R3: a level that did not move cannot produce a hit, whatever the polarity
    a_r3_no_hit_when_still: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(level_i) |=> (hit_o & ~(level_i ^ prev_q)) == '0);
endmodule

// File: rtl/wk_cfg_regs.sv
module wk_cfg_regs
    import wk_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic             sel_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] enable_o,
    output logic [WIDTH-1:0] fall_sel_o
);
    cfg_sel_e target;
    assign target = cfg_sel_e'(sel_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_o   <= '0;
            fall_sel_o <= '0;
        end else if (we_i) begin
            unique case (target)
                CFG_ENABLE: enable_o   <= wdata_i;
                CFG_EDGE:   fall_sel_o <= wdata_i;
            endcase
        end
    end

    // R10: a write to one register leaves the other alone
    a_r10_enable_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && target == CFG_EDGE) |=> $stable(enable_o));
endmodule

// File: rtl/wk_pend_reg.sv
module wk_pend_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hit_i,
    input  logic             xchg_en_i,
    input  logic [WIDTH-1:0] xchg_wdata_i,
    output logic [WIDTH-1:0] pend_o
);
    logic [WIDTH-1:0] pend_d;

    always_comb begin
        pend_d = pend_o | hit_i;
        if (xchg_en_i) pend_d = xchg_wdata_i | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= pend_d;
    end

    // R8: without an exchange no pending bit is ever lost
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !xchg_en_i |=> (pend_o & $past(pend_o)) == $past(pend_o));
    // R7: an edge coinciding with an exchange survives it
    a_r7_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_en_i && hit_i != '0) |=> (pend_o & $past(hit_i)) == $past(hit_i));
endmodule

// File: rtl/wk_req_fsm.sv
module wk_req_fsm
    import wk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    output logic irq_o
);
    req_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_QUIET:  if (want_i)  state_d = REQ_RAISED;
            REQ_RAISED: if (!want_i) state_d = REQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            REQ_QUIET:  irq_o = 1'b0;
            REQ_RAISED: irq_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wk_edge_ctrl.sv
module wk_edge_ctrl
    import wk_pkg::*;
#(
    parameter int WIDTH = PINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [WIDTH-1:0] cfg_wdata,
    input  logic             xchg_en,
    input  logic [WIDTH-1:0] xchg_wdata,
    output logic [WIDTH-1:0] xchg_rdata,
    output logic             irq_o
);
    logic [WIDTH-1:0] level_w, hit_w, enable_w, fall_sel_w, pend_w;

    wk_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(level_w));

    wk_cfg_regs #(.WIDTH(WIDTH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .sel_i(cfg_sel),
        .wdata_i(cfg_wdata), .enable_o(enable_w), .fall_sel_o(fall_sel_w));

    wk_edge_det #(.WIDTH(WIDTH)) u_edge (
        .clk(clk), .rst_n(rst_n), .level_i(level_w),
        .fall_sel_i(fall_sel_w), .hit_o(hit_w));

    wk_pend_reg #(.WIDTH(WIDTH)) u_pend (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_w), .xchg_en_i(xchg_en),
        .xchg_wdata_i(xchg_wdata), .pend_o(pend_w));

    wk_req_fsm u_req (
        .clk(clk), .rst_n(rst_n), .want_i(|(pend_w & enable_w)), .irq_o(irq_o));

    assign xchg_rdata = pend_w;

    // R4: the request follows enabled pending bits one cycle later
    a_r4_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_w & enable_w) != '0) |=> irq_o);
    // R9: with nothing enabled and pending, the request drops next cycle
    a_r9_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_w & enable_w) == '0) |=> !irq_o);
    // R5: an exchange loads at least the written value
    a_r5_xchg_loads: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_en |=> (pend_w & $past(xchg_wdata)) == $past(xchg_wdata));
endmodule

// File: tb/wk_edge_ctrl_bench.sv
module wk_edge_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = '0;
    logic       cfg_we = 1'b0, cfg_sel = 1'b0, xchg_en = 1'b0;
    logic [7:0] cfg_wdata = '0, xchg_wdata = '0;
    logic [7:0] xchg_rdata;
    logic       irq_o;
    int checks = 0, errors = 0, cycles = 0;

    always #2 clk = ~clk;

    wk_edge_ctrl u_wk_edge_ctrl (.*);

    // sel, enable, pin level A, pin level B
    localparam logic [31:0] VEC [6] = '{
        32'h00_FF_00_0F, 32'hFF_FF_FF_F0, 32'h0F_00_33_CC,
        32'hAA_01_55_AA, 32'h55_10_00_FF, 32'h00_80_7F_FF};

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic wr_cfg(logic sel, logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic xchg(logic [7:0] w, output logic [7:0] r);
        @(negedge clk); xchg_en = 1'b1; xchg_wdata = w;
        #1 r = xchg_rdata;
        @(negedge clk); xchg_en = 1'b0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog got=hang exp=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, a, b, sel, en, expv;
        settle(3); rst_n = 1'b1; settle(2);
        // R1: reset state
        check("R1 irq", {7'd0, irq_o}, 8'h00);
        xchg(8'h00, r); check("R1 pend", r, 8'h00);
        // R1: enable cleared, polarity rising: edge pends but no request
        @(negedge clk); pin_i = 8'h01; settle(6);
        check("R1 en cleared irq", {7'd0, irq_o}, 8'h00);
        xchg(8'h00, r); check("R1 polarity rising", r, 8'h01);
        @(negedge clk); pin_i = 8'h00; settle(6); xchg(8'h00, r);

        // table walk: R2 R3 R4 R10
        for (int i = 0; i < 6; i++) begin
            {sel, en, a, b} = VEC[i];
            wr_cfg(1'b1, sel); wr_cfg(1'b0, en);
            @(negedge clk); pin_i = a; settle(6);
            xchg(8'h00, r);
            settle(1);
            @(negedge clk); pin_i = b; settle(6);
            expv = ((~a & b) & ~sel) | ((a & ~b) & sel);
            check("R4 irq vec", {7'd0, irq_o}, {7'd0, |(expv & en)});
            xchg(8'h00, r); check("R2 R3 R10 pend vec", r, expv);
        end

        // R3: polarity change with still pins sets nothing
        wr_cfg(1'b1, 8'h00); settle(4); xchg(8'h00, r);
        wr_cfg(1'b1, 8'hFF); settle(6);
        xchg(8'h00, r); check("R3 polarity flip", r, 8'h00);

        // R8 and R6: sticky, partial clear
        wr_cfg(1'b1, 8'h00); wr_cfg(1'b0, 8'hFF);
        @(negedge clk); pin_i = 8'h00; settle(6); xchg(8'h00, r);
        @(negedge clk); pin_i = 8'h0F; settle(6);
        @(negedge clk); pin_i = 8'h00; settle(6);
        xchg(8'h0C, r); check("R8 sticky", r, 8'h0F);
        xchg(8'h0C, r); check("R6 partial clear", r, 8'h0C);
        check("R4 irq partial", {7'd0, irq_o}, 8'h01);
        // R9: full clear drops the request one cycle later
        xchg(8'h00, r); settle(1);
        check("R9 irq drop", {7'd0, irq_o}, 8'h00);
        // R5: exchange loads value
        xchg(8'hA5, r); check("R5 old", r, 8'h00);
        xchg(8'h00, r); check("R5 loaded", r, 8'hA5);

        // R7: edge lands on the clearing exchange
        xchg(8'h01, r);
        @(negedge clk); pin_i = 8'h20;
        @(negedge clk);
        @(negedge clk); xchg_en = 1'b1; xchg_wdata = 8'h00;
        #1 r = xchg_rdata; check("R7 old", r, 8'h01);
        @(negedge clk); xchg_en = 1'b0;
        xchg(8'h00, r); check("R7 edge kept", r, 8'h20);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule